// File: doc/BRIEF.md
# Scan Line Fill Planner

This block turns one display block descriptor into the word requests for one scan line. A line always holds exactly 38 words. The descriptor gives two values: a tab count, which is the number of blank words placed ahead of the picture, and a width in words. From these the block works out three counts: the leading zero words, the words fetched from the bitmap, and the trailing zero words. It also works out how far the bitmap pointer moves from the start of one line to the start of the next.

A `start` pulse loads a descriptor together with the low two bits of the bitmap start address. After that, each `line_go` pulse plays one line as a stream of requests. Each request is either a run of zero words or a bitmap read of 1, 2, 4 or 16 words, and each one waits for `req_ready`. The block does not touch memory. The data path that consumes the stream does the reads and writes the words.

Top module: `scanline_planner`

## Requirements
- R1: After reset, `req_valid`, `line_done` and `ptr_adv` are all 0.
- R2: When tab + width ≤ 38, a line carries tab leading zero words, then width data words, then 38 − tab − width trailing zero words, and `ptr_adv` equals width.
- R3: When tab + width > 38, the data count is 38 − tab rounded down to even, the trailing zero count is 1 for an odd tab and 0 for an even tab, and `ptr_adv` equals 2·width − data count.
- R4: A phase whose count is zero issues no request. With tab 0 the first request is a data request (`req_zero` = 0), and with no trailing zeros the data phase ends the line.
- R5: With width 0, the first two `line_go` pulses after `start` each produce 38 zero words. Any further `line_go` produces no request and no `line_done` until the next `start`.
- R6: A zero run of r remaining words issues `req_len` = 16 while r ≥ 16, then 4 while r ≥ 4, then 1. `req_zero` = 1 marks zero requests.
- R7: For a data request with r words remaining at current address low bits a: the length is 16 if a = 0 and r ≥ 16; otherwise 4 if a = 0 and r ≥ 4; otherwise 2 if a is even and r ≥ 2; otherwise 1. After each data request, a advances by its length.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_zero` and `req_len` hold their values.
- R9: `line_done` is 1 for exactly the one cycle after the final request of a line is accepted. In that cycle `req_valid` is 0.
- R10: Each line's data phase starts at the address low bits of the previous line's start plus `ptr_adv`, modulo 4. The first line starts at `base_lo`.
- R11: A `line_go` before any `start`, or while a line is in progress, is ignored. A `start` while a line is in progress is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load descriptor pulse |
| tab | input | 5 | Leading blank word count |
| width | input | 8 | Bitmap words per line |
| base_lo | input | 2 | Low address bits of the bitmap start |
| line_go | input | 1 | Begin one scan line |
| req_ready | input | 1 | Consumer accepts the current request |
| req_valid | output | 1 | A request is presented |
| req_zero | output | 1 | 1: zero words, 0: bitmap words |
| req_len | output | 5 | Words in this request (1, 2, 4 or 16) |
| line_done | output | 1 | One-cycle pulse after the final request of a line |
| ptr_adv | output | 9 | Pointer advance per line |

## Verification
The bench targets lines whose tab + width lands exactly on 38, just above it, and far above it at width 255, each with both odd and even tab counts. A design with an off-by-one capacity test, a missing even rounding, or an uncorrected pointer advance shows a wrong word split or a wrong `ptr_adv`. Every request length is compared against a model that tracks address alignment across two consecutive lines, with `req_ready` stalled at intervals. This catches bursts issued from misaligned addresses, a line start that is not advanced by `ptr_adv`, and requests that change while stalled. The zero-width case is driven past its second line to confirm the block goes silent, and `line_go` is pulsed before any descriptor is loaded.

// File: rtl/scanline_planner.sv
module scanline_planner #(
  parameter int LINE_W = 38,
  parameter int TAB_W  = 5,
  parameter int WID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAB_W-1:0] tab,
  input  logic [WID_W-1:0] width,
  input  logic [1:0]       base_lo,
  input  logic             line_go,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             req_zero,
  output logic [4:0]       req_len,
  output logic             line_done,
  output logic [WID_W:0]   ptr_adv
);
  localparam int CNT_W = $clog2(LINE_W + 1);
  localparam int ADV_W = WID_W + 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_LEAD = 2'd1, S_DATA = 2'd2, S_FILL = 2'd3;

  logic [1:0]       st;
  logic [CNT_W-1:0] rem, lead_n, data_n, fill_n;
  logic [1:0]       a, line_lo, blanks;
  logic             zw_q, cfg_ok;

  logic [ADV_W-1:0] sum;
  logic             ovf, zw;
  logic [CNT_W-1:0] avail, dclip, nx_data, nx_fill, nx_lead;
  logic [ADV_W-1:0] nx_adv;

  assign sum     = {1'b0, width} + ADV_W'(tab);
  assign ovf     = sum > ADV_W'(LINE_W);
  assign zw      = (width == '0);
  assign avail   = CNT_W'(LINE_W) - CNT_W'(tab);
  assign dclip   = {avail[CNT_W-1:1], 1'b0};
  assign nx_lead = zw ? '0 : CNT_W'(tab);
  assign nx_data = zw ? '0 : (ovf ? dclip : CNT_W'(width));
  assign nx_fill = zw ? CNT_W'(LINE_W) : (ovf ? CNT_W'(tab[0]) : CNT_W'(LINE_W) - CNT_W'(sum));
  assign nx_adv  = zw ? '0 : (ovf ? {width, 1'b0} - ADV_W'(dclip) : ADV_W'(width));

  logic [4:0] zlen, dlen;
  assign zlen = (rem >= CNT_W'(16)) ? 5'd16 : (rem >= CNT_W'(4)) ? 5'd4 : 5'd1;
  assign dlen = (a == 2'd0 && rem >= CNT_W'(16)) ? 5'd16 :
                (a == 2'd0 && rem >= CNT_W'(4))  ? 5'd4  :
                (!a[0] && rem >= CNT_W'(2))      ? 5'd2  : 5'd1;

  assign req_valid = (st != S_IDLE);
  assign req_zero  = (st != S_DATA);
  assign req_len   = (st == S_DATA) ? dlen : zlen;

  logic hs, go_ok;
  assign hs    = req_valid && req_ready;
  assign go_ok = line_go && st == S_IDLE && cfg_ok && !(zw_q && blanks == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rem <= '0; lead_n <= '0; data_n <= '0; fill_n <= '0;
      a <= '0; line_lo <= '0; blanks <= '0; zw_q <= 1'b0; cfg_ok <= 1'b0;
      ptr_adv <= '0; line_done <= 1'b0;
    end else begin
      line_done <= 1'b0;
      if (start && st == S_IDLE) begin
        lead_n  <= nx_lead;
        data_n  <= nx_data;
        fill_n  <= nx_fill;
        ptr_adv <= nx_adv;
        zw_q    <= zw;
        line_lo <= base_lo;
        blanks  <= '0;
        cfg_ok  <= 1'b1;
      end else if (go_ok) begin
        a <= line_lo;
        if (lead_n != '0)      begin st <= S_LEAD; rem <= lead_n; end
        else if (data_n != '0) begin st <= S_DATA; rem <= data_n; end
        else                   begin st <= S_FILL; rem <= fill_n; end
      end else if (hs) begin
        if (st == S_DATA) a <= a + req_len[1:0];
        if (rem != CNT_W'(req_len)) begin
          rem <= rem - CNT_W'(req_len);
        end else if (st == S_LEAD && data_n != '0) begin
          st <= S_DATA; rem <= data_n;
        end else if (st != S_FILL && fill_n != '0) begin
          st <= S_FILL; rem <= fill_n;
        end else begin
          st        <= S_IDLE;
          line_done <= 1'b1;
          line_lo   <= line_lo + ptr_adv[1:0];
          if (zw_q && blanks != 2'd2) blanks <= blanks + 2'd1;
        end
      end
    end
  end

  logic [6:0] chk_words;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_words <= '0;
    else if (go_ok) chk_words <= '0;
    else if (hs) chk_words <= chk_words + 7'(req_len);
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_zero) && $stable(req_len));
  a_r2_line_total: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> chk_words == 7'(LINE_W));
  a_r9_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> !req_valid && $past(hs));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_zero |-> (req_len == 5'd16 || req_len == 5'd4 || req_len == 5'd1));
  a_r7_burst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_zero && req_len >= 5'd4 |-> a == 2'd0);
  a_r5_blank_stop: assert property (@(posedge clk) disable iff (!rst_n)
    zw_q && blanks == 2'd2 |-> !req_valid);
endmodule

// File: tb/sim_scanline_planner.sv
module sim_scanline_planner;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, line_go = 1'b0, req_ready = 1'b0;
  logic [4:0] tab = '0;
  logic [7:0] width = '0;
  logic [1:0] base_lo = '0;
  logic req_valid, req_zero, line_done;
  logic [4:0] req_len;
  logic [8:0] ptr_adv;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  scanline_planner u0 (.clk(clk), .rst_n(rst_n), .start(start), .tab(tab), .width(width),
    .base_lo(base_lo), .line_go(line_go), .req_ready(req_ready), .req_valid(req_valid),
    .req_zero(req_zero), .req_len(req_len), .line_done(line_done), .ptr_adv(ptr_adv));

  localparam int NV = 10;
  // tab, width, base, lead, data, fill, adv
  localparam int V [NV][7] = '{
    '{0, 10, 0, 0, 10, 28, 10},
    '{10, 3, 2, 10, 3, 25, 3},
    '{4, 34, 1, 4, 34, 0, 34},
    '{5, 33, 3, 5, 33, 0, 33},
    '{3, 40, 0, 3, 34, 1, 46},
    '{31, 20, 2, 31, 6, 1, 34},
    '{0, 255, 0, 0, 38, 0, 472},
    '{2, 37, 2, 2, 36, 0, 38},
    '{17, 21, 0, 17, 21, 0, 21},
    '{1, 1, 1, 1, 1, 36, 1}};

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int zl(input int r);
    return r >= 16 ? 16 : (r >= 4 ? 4 : 1);
  endfunction
  function automatic int dl(input int a, input int r);
    if (a == 0 && r >= 16) return 16;
    if (a == 0 && r >= 4) return 4;
    if (a % 2 == 0 && r >= 2) return 2;
    return 1;
  endfunction

  task automatic load(input int t, input int w, input int b);
    @(negedge clk);
    tab = 5'(t); width = 8'(w); base_lo = 2'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_line(input int el, input int ed, input int ef, input int lo,
                          input bit stall, input string dtag);
    int gl = 0, gd = 0, gf = 0, a = lo, cyc = 0, plen = 0, pz = 0;
    bit pend = 0, phold = 0, fin = 0;
    @(negedge clk); line_go = 1'b1;
    @(negedge clk); line_go = 1'b0;
    while (!fin && cyc < 500) begin
      int ez, elen;
      if (pend) begin
        if (gl < el) gl += plen;
        else if (gd < ed) begin gd += plen; a = (a + plen) % 4; end
        else gf += plen;
        pend = 0;
      end
      if (gl + gd + gf >= el + ed + ef) begin
        check(line_done && !req_valid, "R9", int'({line_done, req_valid}), 2);
        check(gl == el && gd == ed && gf == ef, "R2", gl * 10000 + gd * 100 + gf,
              el * 10000 + ed * 100 + ef);
        fin = 1;
        req_ready = 1'b0;
      end else begin
        if (gl < el) begin ez = 1; elen = zl(el - gl); end
        else if (gd < ed) begin ez = 0; elen = dl(a, ed - gd); end
        else begin ez = 1; elen = zl(ef - gf); end
        check(req_valid == 1'b1, "R4", int'(req_valid), 1);
        check(int'(req_zero) == ez, "R4", int'(req_zero), ez);
        check(int'(req_len) == elen, ez ? "R6" : dtag, int'(req_len), elen);
        if (phold) check(int'(req_len) == plen && int'(req_zero) == pz, "R8",
                         int'(req_len), plen);
        req_ready = !(stall && (cyc % 3 == 1));
        plen = int'(req_len); pz = int'(req_zero);
        pend = req_ready;
        phold = !req_ready;
        @(negedge clk);
      end
      cyc++;
    end
    if (!fin) check(0, "R9", 0, 1);
    @(negedge clk);
    check(!line_done, "R9", int'(line_done), 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired, R9 actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!req_valid && !line_done && ptr_adv == 0, "R1", int'(ptr_adv) + int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: line_go with no descriptor loaded
    line_go = 1'b1; @(negedge clk); line_go = 1'b0;
    repeat (4) begin
      check(!req_valid && !line_done, "R11", int'(req_valid), 0);
      @(negedge clk);
    end

    for (int i = 0; i < NV; i++) begin
      int lo2;
      load(V[i][0], V[i][1], V[i][2]);
      check(int'(ptr_adv) == V[i][6], (V[i][0] + V[i][1] > 38) ? "R3" : "R2",
            int'(ptr_adv), V[i][6]);
      run_line(V[i][3], V[i][4], V[i][5], V[i][2], 1'b0, "R7");
      lo2 = (V[i][2] + V[i][6]) % 4;
      run_line(V[i][3], V[i][4], V[i][5], lo2, 1'b1, "R10");
    end

    // R11: line_go during an active line is ignored (line still ends after 38 words)
    load(10, 3, 0);
    @(negedge clk); line_go = 1'b1; @(negedge clk);
    check(req_valid, "R11", int'(req_valid), 1);
    repeat (3) @(negedge clk);
    line_go = 1'b0;
    req_ready = 1'b1;
    begin
      int words = 0, k = 0;
      while (!line_done && k < 100) begin
        if (req_valid) words += int'(req_len);
        @(negedge clk); k++;
      end
      check(words == 38, "R11", words, 38);
    end
    req_ready = 1'b0;
    @(negedge clk);
    check(!req_valid, "R11", int'(req_valid), 0);

    // R5: zero width gives two blank lines then silence
    load(7, 0, 1);
    check(ptr_adv == 0, "R5", int'(ptr_adv), 0);
    run_line(0, 0, 38, 1, 1'b0, "R5");
    run_line(0, 0, 38, 1, 1'b1, "R5");
    line_go = 1'b1; @(negedge clk); line_go = 1'b0;
    repeat (6) begin
      check(!req_valid && !line_done, "R5", int'(req_valid), 0);
      @(negedge clk);
    end
    load(0, 10, 0);
    run_line(0, 10, 28, 0, 1'b0, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule